// File: doc/BRIEF.md
# Parallel Port Host Control Register

This block is the host-side control register of a PC-style parallel port. Software writes one byte over a simple register bus. The stored bits drive the four active-low handshake lines toward the connector. Some of those lines are inverted on the way out and some are not. The register also decides whether the port drives the data bus. The port mode, supplied by the extended control logic, can override that direction choice. For example, the plain compatibility mode and the FIFO-fed compatibility mode always drive the bus, and peripheral-emulation mode never does.

The acknowledge line from the connector is brought into the clock domain through a synchronizer. Each rising edge of that line can raise a one-cycle interrupt request, but only when software has enabled it. In peripheral-emulation mode, an active (low) acknowledge also clears the auto-feed bit in hardware. This lets software see that the handshake has completed.

Top module: `pp_ctrl_reg`

## Requirements
- R1: A synchronous active-high reset sets the stored control bits to strobe=0, autofd=0, init=1, select=1, irq_en=0, dir=0. The readback is then 0x0C, with strobe_n=1, autofd_n=1, init_n=1, select_in_n=0, data_oe=1 and ack_irq=0.
- R2: The register layout is bit 0 strobe, bit 1 autofd, bit 2 init, bit 3 select, bit 4 irq_en and bit 5 dir. Bits 7:6 are ignored on write and always read 0. A write takes effect at the clock edge that samples wr_en, and rd_data shows the new value from then on.
- R3: strobe_n, autofd_n and select_in_n are the inverses of bits 0, 1 and 3.
- R4: init_n equals bit 2 without inversion.
- R5: In mode 000 (compatibility) and mode 010 (FIFO compatibility), bit 5 reads 0 and data_oe is 1, whatever value is stored.
- R6: In mode 100 (peripheral emulation), bit 5 reads 1 and data_oe is 0, whatever value is stored.
- R7: In modes 001, 011, 101, 110 and 111, bit 5 reads the stored value and data_oe is its inverse.
- R8: ack_n passes through two synchronizer flops. With irq_en=1, a low-to-high change of ack_n gives ack_irq high for exactly one cycle, in the third cycle after the change.
- R9: With irq_en=0, edges on ack_n never raise ack_irq.
- R10: In mode 100, while the synchronized ack_n is low, autofd is cleared. autofd_n goes high in the third cycle after ack_n falls. In other modes ack_n never changes autofd.
- R11: When a write sets autofd in the same cycle as the hardware clear, the clear wins.
- R12: A mode that forces the direction does not change the stored dir bit. When the mode returns to a non-forcing value, the stored value is visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback (effective dir bit) |
| mode | input | 3 | Current port mode |
| ack_n | input | 1 | Raw acknowledge line from the connector |
| strobe_n | output | 1 | Data strobe, active low |
| autofd_n | output | 1 | Auto line feed, active low |
| init_n | output | 1 | Initialize, active low |
| select_in_n | output | 1 | Select-in, active low |
| data_oe | output | 1 | Data bus drive enable |
| ack_irq | output | 1 | One-cycle acknowledge interrupt request |

## Verification
Writes and their pin results are due at the first clock edge that samples wr_en. Mode-driven direction forcing is combinational, so it shows before the next edge. The bench therefore drives at the falling edge and samples at the next falling edge. Acknowledge effects pass through the two synchronizer stages plus one output or register stage. For these, the bench records the outputs at the falling edge after each of the next four rising edges. It expects the interrupt pulse, or the auto-feed clear, exactly in the third of those samples and nowhere else.

// File: rtl/pp_ctrl_pkg.sv
package pp_ctrl_pkg;

    localparam int REG_W  = 8;
    localparam int MODE_W = 3;

    localparam int BIT_STROBE = 0;
    localparam int BIT_AUTOFD = 1;
    localparam int BIT_INIT   = 2;
    localparam int BIT_SELECT = 3;
    localparam int BIT_IRQEN  = 4;
    localparam int BIT_DIR    = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT  = 3'b000,
        MODE_BIDIR   = 3'b001,
        MODE_FIFO    = 3'b010,
        MODE_EXT     = 3'b011,
        MODE_PERIPH  = 3'b100,
        MODE_SPARE   = 3'b101,
        MODE_LOOP    = 3'b110,
        MODE_SETUP   = 3'b111
    } pp_mode_e;

    // Stored control bits, msb first so the packed order matches the bus layout
    typedef struct packed {
        logic dir;
        logic irq_en;
        logic select;
        logic init;
        logic autofd;
        logic strobe;
    } pp_ctrl_t;

    localparam int CTRL_W = $bits(pp_ctrl_t);

    typedef struct packed {
        logic strobe_n;
        logic autofd_n;
        logic init_n;
        logic select_in_n;
    } pp_pins_t;

    typedef enum logic [1:0] {
        DIR_SRC_OUT  = 2'b00,
        DIR_SRC_IN   = 2'b01,
        DIR_SRC_SOFT = 2'b10
    } pp_dir_src_e;

    localparam pp_ctrl_t CTRL_RESET = '{
        dir:    1'b0,
        irq_en: 1'b0,
        select: 1'b1,
        init:   1'b1,
        autofd: 1'b0,
        strobe: 1'b0
    };

    function automatic pp_ctrl_t ctrl_from_bits(input logic [CTRL_W-1:0] b);
        return pp_ctrl_t'(b);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_bus(input pp_ctrl_t c);
        return {{(REG_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic pp_pins_t ctrl_to_pins(input pp_ctrl_t c);
        pp_pins_t p;
        p.strobe_n    = ~c.strobe;
        p.autofd_n    = ~c.autofd;
        p.init_n      = c.init;
        p.select_in_n = ~c.select;
        return p;
    endfunction

    function automatic pp_dir_src_e dir_source(input pp_mode_e m);
        case (m)
            MODE_COMPAT, MODE_FIFO: return DIR_SRC_OUT;
            MODE_PERIPH:            return DIR_SRC_IN;
            default:                return DIR_SRC_SOFT;
        endcase
    endfunction

endpackage

// File: rtl/pp_ack_sync.sv
module pp_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_raw,
    output logic ack_active,
    output logic ack_rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= ack_n_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], ack_n_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign ack_active = ~chain_q[LAST];
    assign ack_rise   = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pp_dir_ctl.sv
module pp_dir_ctl
    import pp_ctrl_pkg::*;
(
    input  pp_mode_e mode,
    input  logic     soft_dir,
    output logic     dir_eff,
    output logic     data_oe,
    output logic     periph
);
    pp_dir_src_e src;

    always_comb begin
        src = dir_source(mode);
        case (src)
            DIR_SRC_OUT: dir_eff = 1'b0;
            DIR_SRC_IN:  dir_eff = 1'b1;
            default:     dir_eff = soft_dir;
        endcase
        data_oe = ~dir_eff;
        periph  = (src == DIR_SRC_IN);
    end

endmodule

// File: rtl/pp_ctrl_core.sv
module pp_ctrl_core
    import pp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_bits,
    input  logic              hw_clr_autofd,
    input  logic              ack_rise,
    output pp_ctrl_t          ctrl,
    output logic              irq
);
    pp_ctrl_t ctrl_q;
    logic     irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr_en)         ctrl_q <= ctrl_from_bits(wr_bits);
            if (hw_clr_autofd) ctrl_q.autofd <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ack_rise & ctrl_q.irq_en;
    end

    assign ctrl = ctrl_q;
    assign irq  = irq_q;

endmodule

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg
    import pp_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [MODE_W-1:0] mode,
    input  logic             ack_n,
    output logic             strobe_n,
    output logic             autofd_n,
    output logic             init_n,
    output logic             select_in_n,
    output logic             data_oe,
    output logic             ack_irq
);
    pp_mode_e mode_e;
    pp_ctrl_t ctrl;
    pp_ctrl_t ctrl_view;
    pp_pins_t pins;
    logic     ack_active;
    logic     ack_rise;
    logic     dir_eff;
    logic     periph;
    logic     hw_clr;

    assign mode_e = pp_mode_e'(mode);

    pp_ack_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .ack_n_raw  (ack_n),
        .ack_active (ack_active),
        .ack_rise   (ack_rise)
    );

    pp_dir_ctl dir_i (
        .mode     (mode_e),
        .soft_dir (ctrl.dir),
        .dir_eff  (dir_eff),
        .data_oe  (data_oe),
        .periph   (periph)
    );

    assign hw_clr = periph & ack_active;

    pp_ctrl_core core_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_bits       (wr_data[CTRL_W-1:0]),
        .hw_clr_autofd (hw_clr),
        .ack_rise      (ack_rise),
        .ctrl          (ctrl),
        .irq           (ack_irq)
    );

    always_comb begin
        ctrl_view     = ctrl;
        ctrl_view.dir = dir_eff;
        pins          = ctrl_to_pins(ctrl);
    end

    assign rd_data     = ctrl_to_bus(ctrl_view);
    assign strobe_n    = pins.strobe_n;
    assign autofd_n    = pins.autofd_n;
    assign init_n      = pins.init_n;
    assign select_in_n = pins.select_in_n;

endmodule

// File: rtl/pp_ctrl_reg_chk.sv
module pp_ctrl_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] mode,
    input logic       strobe_n,
    input logic       init_n,
    input logic       select_in_n,
    input logic       data_oe,
    input logic       ack_irq
);
    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (rst || (rd_data == 8'h0C && !ack_irq && strobe_n && init_n && !select_in_n)));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b00);

    // R2
    irqen_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[4] == $past(wr_data[4])));

    // R3
    strobe_pin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (strobe_n == !$past(wr_data[0]) && select_in_n == !$past(wr_data[3])));

    // R4
    init_pin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (init_n == $past(wr_data[2])));

    // R5
    forced_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000 || mode == 3'b010) |-> (data_oe && !rd_data[5]));

    // R6
    forced_in_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b100) |-> (!data_oe && rd_data[5]));

    // R7
    soft_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'b000 && mode != 3'b010 && mode != 3'b100) |-> (data_oe == !rd_data[5]));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_irq |=> !ack_irq);

    // R9
    irq_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ack_irq |-> $past(rd_data[4]));

endmodule

bind pp_ctrl_reg pp_ctrl_reg_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .mode        (mode),
    .strobe_n    (strobe_n),
    .init_n      (init_n),
    .select_in_n (select_in_n),
    .data_oe     (data_oe),
    .ack_irq     (ack_irq)
);

// File: tb/pp_ctrl_reg_tb.sv
module pp_ctrl_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] mode = 3'b000;
    logic       ack_n = 1'b1;
    logic       strobe_n, autofd_n, init_n, select_in_n, data_oe, ack_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pp_ctrl_reg dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .mode        (mode),
        .ack_n       (ack_n),
        .strobe_n    (strobe_n),
        .autofd_n    (autofd_n),
        .init_n      (init_n),
        .select_in_n (select_in_n),
        .data_oe     (data_oe),
        .ack_irq     (ack_irq)
    );

    // mode, write data, expected readback, expected {strobe_n,autofd_n,init_n,select_in_n,data_oe}
    localparam logic [23:0] VEC [8] = '{
        {3'b000, 8'h3F, 8'h1F, 5'b00101},
        {3'b001, 8'h3F, 8'h3F, 5'b00100},
        {3'b010, 8'h20, 8'h00, 5'b11011},
        {3'b100, 8'h00, 8'h20, 5'b11010},
        {3'b011, 8'hC5, 8'h05, 5'b01111},
        {3'b110, 8'h2A, 8'h2A, 5'b10000},
        {3'b111, 8'h0C, 8'h0C, 5'b11101},
        {3'b101, 8'h22, 8'h22, 5'b10010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    function automatic logic [4:0] pins();
        return {strobe_n, autofd_n, init_n, select_in_n, data_oe};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 readback", rd_data, 8'h0C);
        check("R1 pins", pins(), 5'b11101);
        check("R1 irq", ack_irq, 1'b0);

        // R2 R3 R4 R5 R6 R7 table walk
        foreach (VEC[i]) begin
            mode = VEC[i][23:21];
            write_reg(VEC[i][20:13]);
            check("R2/R5/R6/R7 readback", rd_data, VEC[i][12:5]);
            check("R3/R4/R5/R6/R7 pins", pins(), VEC[i][4:0]);
        end

        // R12 stored dir survives forcing mode
        mode = 3'b000;
        write_reg(8'h20);
        check("R12 forced read", rd_data[5], 1'b0);
        check("R12 forced oe", data_oe, 1'b1);
        mode = 3'b001;
        #1;
        check("R12 restored read", rd_data[5], 1'b1);
        check("R12 restored oe", data_oe, 1'b0);

        // R8 interrupt timing
        write_reg(8'h10);
        ack_n = 1'b0;
        repeat (4) tick();
        ack_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            seen[k] = ack_irq;
        end
        check("R8 irq cycles", seen[3:0], 4'b0100);

        // R9 disabled interrupt
        write_reg(8'h00);
        ack_n = 1'b0;
        repeat (4) tick();
        ack_n = 1'b1;
        seen = '0;
        for (int k = 0; k < 5; k++) begin
            tick();
            seen[k] = ack_irq;
        end
        check("R9 no irq", seen, 5'b00000);

        // R10 hardware clear in peripheral mode
        mode = 3'b100;
        write_reg(8'h02);
        check("R10 autofd set", autofd_n, 1'b0);
        ack_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            seen[k] = autofd_n;
        end
        check("R10 clear timing", seen[3:0], 4'b1100);
        check("R10 readback cleared", rd_data[1], 1'b0);

        // R11 clear wins over write while ack held low
        write_reg(8'h02);
        check("R11 clear wins", autofd_n, 1'b1);
        check("R11 readback", rd_data[1], 1'b0);
        ack_n = 1'b1;
        repeat (3) tick();
        write_reg(8'h02);
        check("R11 write after release", autofd_n, 1'b0);

        // R10 no clear outside peripheral mode
        mode = 3'b001;
        write_reg(8'h02);
        ack_n = 1'b0;
        repeat (5) tick();
        check("R10 other mode untouched", autofd_n, 1'b0);
        ack_n = 1'b1;
        repeat (3) tick();

        finish_run();
    end

endmodule